// File: doc/BRIEF.md
# Masked Transition-Detect Interrupt Controller

This block watches three groups of per-channel alarm bits: loss of signal, driver failure and alarm indication. Each group carries one bit for each of four channels, already synchronous to the block clock. Every clock the block registers the alarm bits and compares the new sample with the one taken a cycle earlier. A change in either direction on a bit whose enable is set is recorded in that group's pending register. A single active-low interrupt line stays asserted while any pending bit is set.

The host reaches three registers per group through a simple register port: the live status, the enable mask and the pending record. Read data is registered. It returns one cycle after the read strobe, marked by a valid strobe. A read of a pending register returns its contents and clears it in the same step. An event that arrives in the very cycle of that clearing read is kept, so no change is lost.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset, irq_n is 1 and every enable and pending register reads 0.
- R2: A read of a live status register (loss 04h, driver 05h, alarm 13h) returns the alarm inputs as sampled one clock earlier, in bits [3:0], whatever the enables hold. Writes to these addresses change nothing.
- R3: A 0-to-1 change on an enabled alarm bit sets the matching pending bit and drives irq_n low after the clock edge that samples the change.
- R4: A 1-to-0 change on an enabled alarm bit does the same as R3.
- R5: A change on a bit whose enable is 0 sets no pending bit and leaves irq_n unchanged.
- R6: The enable registers (loss 06h, driver 07h, alarm 14h) are written and read in bits [3:0]. Bits [7:4] read as 0.
- R7: A read of a pending register (loss 08h, driver 09h, alarm 15h) returns its value with reg_rvalid high on the next cycle and clears it. irq_n returns to 1 once all three pending registers are zero.
- R8: irq_n stays low while any pending register is non-zero, including after one of several busy groups has been cleared.
- R9: If a change on an enabled bit lands in the same cycle as a clearing read of its group, that pending bit stays set after the read.
- R10: Reads of unmapped addresses return 0. Writes to pending registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| los_i | input | 4 | Loss-of-signal status, one bit per channel |
| dfm_i | input | 4 | Driver-failure status, one bit per channel |
| ais_i | input | 4 | Alarm-indication status, one bit per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
The hardest case to reach is a new change on an alarm bit that falls in exactly the cycle when the host reads that bit's pending register. The clear and the set then fight over the same flop. The bench first leaves the bit pending. It then drives the read strobe and the reversed alarm input on the same falling edge, so that one rising edge samples both. It expects the read to return the old pending value, irq_n to stay low, and a second read to still show the bit.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_LOS = 2'd0,
    SRC_DFM = 2'd1,
    SRC_AIS = 2'd2
  } src_e;

  // address of the live status register of a source
  function automatic int live_addr(input int s);
    case (s)
      0:       return 'h04;
      1:       return 'h05;
      default: return 'h13;
    endcase
  endfunction

  // address of the enable register of a source
  function automatic int en_addr(input int s);
    case (s)
      0:       return 'h06;
      1:       return 'h07;
      default: return 'h14;
    endcase
  endfunction

  // address of the pending (latched interrupt) register of a source
  function automatic int pend_addr(input int s);
    case (s)
      0:       return 'h08;
      1:       return 'h09;
      default: return 'h15;
    endcase
  endfunction

  // bits that changed between two samples, either direction
  function automatic logic [7:0] change_bits(input logic [7:0] now_v, input logic [7:0] old_v);
    return now_v ^ old_v;
  endfunction

  // pending next state: a set wins over a clear in the same cycle
  function automatic logic [7:0] pend_update(input logic [7:0] pend,
                                             input logic [7:0] set_v,
                                             input logic       clr);
    return (clr ? 8'h00 : pend) | set_v;
  endfunction

endpackage

// File: rtl/alarm_irq_source.sv
module alarm_irq_source
  import alarm_irq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] stat_i,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_wdata,
  input  logic           pend_clr,
  output logic [NCH-1:0] live_o,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] set_o,
  output logic [NCH-1:0] pend_nxt_o
);

  logic [NCH-1:0] live_q, en_q, pend_q;
  logic [NCH-1:0] chg;
  logic [7:0]     chg_w, pend_w;

  assign chg_w = change_bits(8'(stat_i), 8'(live_q));
  assign chg   = chg_w[NCH-1:0];
  assign set_o = chg & en_q;

  assign pend_w     = pend_update(8'(pend_q), 8'(set_o), pend_clr);
  assign pend_nxt_o = pend_w[NCH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      live_q <= stat_i;
      pend_q <= pend_nxt_o;
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign live_o = live_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/alarm_irq_regport.sv
module alarm_irq_regport
  import alarm_irq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NCH-1:0]    live_i [NSRC],
  input  logic [NCH-1:0]    en_i   [NSRC],
  input  logic [NCH-1:0]    pend_i [NSRC],
  output logic [NSRC-1:0]   en_wr_o,
  output logic [NSRC-1:0]   pend_clr_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);

  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;
  int            addr_i;

  assign addr_i = int'(reg_addr);

  for (genvar s = 0; s < NSRC; s++) begin : g_dec
    assign en_wr_o[s]    = reg_wr && (addr_i == en_addr(s));
    assign pend_clr_o[s] = reg_rd && (addr_i == pend_addr(s));
  end

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (addr_i == live_addr(s)) rd_mux[NCH-1:0] = live_i[s];
      if (addr_i == en_addr(s))   rd_mux[NCH-1:0] = en_i[s];
      if (addr_i == pend_addr(s)) rd_mux[NCH-1:0] = pend_i[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/alarm_irq_outlatch.sv
module alarm_irq_outlatch #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] pend_nxt,
  output logic             irq_n
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_nxt;
  end

  assign irq_n = ~irq_q;

endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_irq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    los_i,
  input  logic [NCH-1:0]    dfm_i,
  input  logic [NCH-1:0]    ais_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_n
);

  localparam int NBITS = NSRC * NCH;

  logic [NCH-1:0]  stat_arr [NSRC];
  logic [NCH-1:0]  live_arr [NSRC];
  logic [NCH-1:0]  en_arr   [NSRC];
  logic [NCH-1:0]  pend_arr [NSRC];
  logic [NCH-1:0]  set_arr  [NSRC];
  logic [NCH-1:0]  nxt_arr  [NSRC];
  logic [NSRC-1:0] en_wr;
  logic [NSRC-1:0] pend_clr;

  // named event wires for the checker
  logic [NBITS-1:0] pend_all;
  logic [NBITS-1:0] set_all;
  logic [NBITS-1:0] nxt_all;
  logic             clr_any;

  assign stat_arr[SRC_LOS] = los_i;
  assign stat_arr[SRC_DFM] = dfm_i;
  assign stat_arr[SRC_AIS] = ais_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    alarm_irq_source #(.NCH(NCH)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_i    (stat_arr[s]),
      .en_wr     (en_wr[s]),
      .en_wdata  (reg_wdata[NCH-1:0]),
      .pend_clr  (pend_clr[s]),
      .live_o    (live_arr[s]),
      .en_o      (en_arr[s]),
      .pend_o    (pend_arr[s]),
      .set_o     (set_arr[s]),
      .pend_nxt_o(nxt_arr[s])
    );
    assign pend_all[s*NCH +: NCH] = pend_arr[s];
    assign set_all[s*NCH +: NCH]  = set_arr[s];
    assign nxt_all[s*NCH +: NCH]  = nxt_arr[s];
  end

  if (NCH < DW) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DW-1:NCH];
  end

  assign clr_any = |pend_clr;

  alarm_irq_regport #(.NCH(NCH), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .live_i    (live_arr),
    .en_i      (en_arr),
    .pend_i    (pend_arr),
    .en_wr_o   (en_wr),
    .pend_clr_o(pend_clr),
    .rdata_o   (reg_rdata),
    .rvalid_o  (reg_rvalid)
  );

  alarm_irq_outlatch #(.NBITS(NBITS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_nxt(nxt_all),
    .irq_n   (irq_n)
  );

endmodule

// File: rtl/alarm_irq_checks.sv
module alarm_irq_checks #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             reg_rd,
  input logic             reg_rvalid,
  input logic [NBITS-1:0] pend_all,
  input logic [NBITS-1:0] set_all,
  input logic             clr_any
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> irq_n);

  p_event_asserts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> !irq_n);

  p_masked_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_all == '0) && !clr_any) |=> $stable(pend_all));

  p_read_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  p_irq_follows_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == (pend_all == '0));

  p_set_survives_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((pend_all & $past(set_all)) == $past(set_all)));

endmodule

bind alarm_irq_top alarm_irq_checks #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_n     (irq_n),
  .reg_rd    (reg_rd),
  .reg_rvalid(reg_rvalid),
  .pend_all  (pend_all),
  .set_all   (set_all),
  .clr_any   (clr_any)
);

// File: tb/alarm_irq_top_bench.sv
module alarm_irq_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] los_i = '0, dfm_i = '0, ais_i = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic       irq_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  alarm_irq_top u_alarm_irq_top (
    .clk(clk), .rst_n(rst_n), .los_i(los_i), .dfm_i(dfm_i), .ais_i(ais_i),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq_n(irq_n)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("read data with empty scoreboard FAIL: got %02h", reg_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (reg_rdata !== e.val) begin
          fails++;
          $display("FAIL %s: rdata %02h, expected %02h", e.tag, reg_rdata, e.val);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp_v, input string tag);
    tests++;
    if (irq_n !== exp_v) begin
      fails++;
      $display("FAIL %s: irq_n %b, expected %b", tag, irq_n, exp_v);
    end
  endtask

  task automatic set_stat(input logic [3:0] l, input logic [3:0] d, input logic [3:0] a);
    @(negedge clk);
    los_i = l; dfm_i = d; ais_i = a;
  endtask

  task automatic wr(input logic [4:0] addr, input logic [7:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] addr, input logic [7:0] exp_v, input string tag);
    exp_t e;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = addr;
    e.val = exp_v; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk_irq(1'b1, "R1 reset irq_n");
    rd(5'h06, 8'h00, "R1 los enable reset");
    rd(5'h07, 8'h00, "R1 dfm enable reset");
    rd(5'h14, 8'h00, "R1 ais enable reset");
    rd(5'h08, 8'h00, "R1 los pending reset");
    rd(5'h09, 8'h00, "R1 dfm pending reset");
    rd(5'h15, 8'h00, "R1 ais pending reset");

    // changes with all enables off
    set_stat(4'b0011, 4'b0000, 4'b0000);
    step();
    chk_irq(1'b1, "R5 masked change irq_n");
    rd(5'h04, 8'h03, "R2 los live");
    rd(5'h08, 8'h00, "R5 masked pending");

    wr(5'h04, 8'hFF);
    rd(5'h04, 8'h03, "R2 live write ignored");
    wr(5'h08, 8'hFF);
    rd(5'h08, 8'h00, "R10 pending write ignored");
    rd(5'h1F, 8'h00, "R10 unmapped read");
    chk_irq(1'b1, "R10 pending write no irq");

    wr(5'h06, 8'h05);
    rd(5'h06, 8'h05, "R6 los enable");
    wr(5'h06, 8'hF5);
    rd(5'h06, 8'h05, "R6 upper bits zero");
    wr(5'h14, 8'h0F);
    rd(5'h14, 8'h0F, "R6 ais enable");
    wr(5'h07, 8'h08);
    rd(5'h07, 8'h08, "R6 dfm enable");

    // rising change on enabled los bit 2
    set_stat(4'b0111, 4'b0000, 4'b0000);
    step();
    chk_irq(1'b0, "R3 rise asserts");
    rd(5'h08, 8'h04, "R3 rise pending");
    chk_irq(1'b1, "R7 clear releases irq");
    rd(5'h08, 8'h00, "R7 cleared by read");

    // falling change on enabled los bit 0
    set_stat(4'b0110, 4'b0000, 4'b0000);
    step();
    chk_irq(1'b0, "R4 fall asserts");
    rd(5'h08, 8'h01, "R4 fall pending");
    chk_irq(1'b1, "R7 release after fall");

    // disabled bit 1 falls
    set_stat(4'b0100, 4'b0000, 4'b0000);
    step();
    chk_irq(1'b1, "R5 disabled bit");
    rd(5'h08, 8'h00, "R5 disabled pending");
    rd(5'h04, 8'h04, "R2 live independent of enable");

    // two groups at once
    set_stat(4'b0100, 4'b1000, 4'b0001);
    step();
    chk_irq(1'b0, "R3 two groups assert");
    rd(5'h05, 8'h08, "R2 dfm live");
    rd(5'h13, 8'h01, "R2 ais live");
    rd(5'h09, 8'h08, "R3 dfm pending");
    chk_irq(1'b0, "R8 still low with ais pending");
    rd(5'h15, 8'h01, "R3 ais pending");
    chk_irq(1'b1, "R7 all clear");

    // collision of clearing read and new change
    set_stat(4'b0100, 4'b1000, 4'b0011);
    step();
    chk_irq(1'b0, "R9 setup pending");
    begin
      exp_t e;
      @(negedge clk);
      ais_i = 4'b0001;
      reg_rd = 1'b1; reg_addr = 5'h15;
      e.val = 8'h02; e.tag = "R9 collision read";
      exp_q.push_back(e);
      @(negedge clk);
      reg_rd = 1'b0;
    end
    chk_irq(1'b0, "R9 irq kept");
    rd(5'h15, 8'h02, "R9 bit kept");
    chk_irq(1'b1, "R7 release after collision");

    repeat (3) step();
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule